// File: doc/BRIEF.md
# Bypassable Read-Only Cache for Embedding Vectors

This block is a small set-associative cache that sits next to a memory rank. It keeps embedding vectors that were fetched recently. A client issues one lookup at a time: an address plus a keep flag. With the flag set, a request that hits returns the stored line one cycle later and causes no memory traffic. A request that misses is sent to memory, and the returned word fills a line chosen by least-recently-used order within its set. With the flag clear, the request goes straight to memory and leaves the cache untouched.

Lines enter the cache only through miss fills. Nothing ever writes them afterwards, so the block keeps no dirty state and never writes back. Only one memory fetch can be outstanding at a time, and the client is stalled until it returns. Two counters report cacheable hits and cacheable misses.

Top module: `embed_cache`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1, both counters are 0 and every line is invalid, so the first cacheable access to any address misses.
- R2: A cacheable request (`req_keep`=1) that hits raises no memory request. In the cycle after acceptance it returns the stored word with `rsp_valid`=1 and `rsp_hit`=1.
- R3: A request that misses or bypasses drives `mem_req_valid`=1 with `mem_req_addr` equal to the request address in its acceptance cycle. In the cycle after `mem_rsp_valid` it returns `mem_rsp_data` with `rsp_hit`=0.
- R4: A cacheable miss allocates the returned word, so the next cacheable access to the same address hits with the same data.
- R5: The set index is the low log2(SETS) address bits and the tag is the remaining upper bits. Each set holds WAYS (default 4) distinct tags at once.
- R6: A cacheable miss in a full set evicts the least recently used line of that set. A hit makes its line the most recent.
- R7: A request with `req_keep`=0 always goes to memory, even if the line is present, and returns `rsp_hit`=0. It does not allocate, does not change the LRU order and changes neither counter.
- R8: From the acceptance of a request that goes to memory until `mem_rsp_valid` is seen, `req_ready` is 0. Requests presented in that window are not accepted and raise no memory request.
- R9: `hit_count` increments once per cacheable hit and `miss_count` once per cacheable miss, both in the acceptance cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | ADDR_W | Lookup address |
| req_keep | input | 1 | 1: may use and allocate the cache; 0: bypass |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| mem_req_valid | output | 1 | Fetch request to memory (one-cycle pulse) |
| mem_req_addr | output | ADDR_W | Fetch address |
| mem_rsp_valid | input | 1 | Memory returns fetched word |
| mem_rsp_data | input | DATA_W | Fetched word |
| rsp_valid | output | 1 | Response to the client |
| rsp_data | output | DATA_W | Returned word |
| rsp_hit | output | 1 | Response was served by the cache |
| hit_count | output | CNT_W | Cacheable hit counter |
| miss_count | output | CNT_W | Cacheable miss counter |

## Verification
A corrupted tag or valid bit shows up at the next access to that set. The response then either has the wrong `rsp_hit` value or raises a memory request that should not happen, visible in the acceptance cycle itself. Corrupted LRU ages show up only later, when a full set evicts the wrong line and a later access to the survivor misses. The random phase therefore revisits a small address pool many times. A stuck busy state shows on `req_ready`, which is compared with the model on every clock.

// File: rtl/embed_cache.sv
module embed_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_keep,
  output logic              req_ready,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int WAY_W = AGE_W;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [DATA_W-1:0] data_q [SETS][WAYS];
  logic [AGE_W-1:0]  age_q  [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];

  logic              busy_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_keep_q;
  logic [WAY_W-1:0]  pend_way_q;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tg;
  logic [WAYS-1:0]  hit_vec;
  logic [WAY_W-1:0] hit_way, victim;
  logic             lookup_hit, accept, fill;
  logic             touch_en;
  logic [IDX_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;

  assign idx = req_addr[IDX_W-1:0];
  assign tg  = req_addr[ADDR_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = vld_q[idx][w] && (tag_q[idx][w] == tg);
  end

  always_comb begin
    hit_way = '0;
    victim  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (age_q[idx][w] == AGE_W'(WAYS - 1)) victim = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[idx][w]) victim = WAY_W'(w);
  end

  assign req_ready     = !busy_q;
  assign accept        = req_valid && !busy_q;
  assign lookup_hit    = req_keep && (|hit_vec);
  assign mem_req_valid = accept && !lookup_hit;
  assign mem_req_addr  = req_addr;
  assign fill          = busy_q && mem_rsp_valid && pend_keep_q;

  assign touch_en  = (accept && lookup_hit) || fill;
  assign touch_set = fill ? pend_addr_q[IDX_W-1:0] : idx;
  assign touch_way = fill ? pend_way_q : hit_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++)
        if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      age_q[touch_set][touch_way] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag_q[pend_addr_q[IDX_W-1:0]][pend_way_q]  <= pend_addr_q[ADDR_W-1:IDX_W];
      data_q[pend_addr_q[IDX_W-1:0]][pend_way_q] <= mem_rsp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      busy_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_keep_q <= 1'b0;
      pend_way_q  <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_hit     <= 1'b0;
      hit_count   <= '0;
      miss_count  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        if (lookup_hit) begin
          rsp_valid <= 1'b1;
          rsp_data  <= data_q[idx][hit_way];
          rsp_hit   <= 1'b1;
          hit_count <= hit_count + 1'b1;
        end else begin
          busy_q      <= 1'b1;
          pend_addr_q <= req_addr;
          pend_keep_q <= req_keep;
          pend_way_q  <= victim;
          if (req_keep) miss_count <= miss_count + 1'b1;
        end
      end else if (busy_q && mem_rsp_valid) begin
        busy_q    <= 1'b0;
        rsp_valid <= 1'b1;
        rsp_data  <= mem_rsp_data;
        rsp_hit   <= 1'b0;
        if (pend_keep_q) vld_q[pend_addr_q[IDX_W-1:0]][pend_way_q] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/embed_cache_chk.sv
module embed_cache_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_keep,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_rsp_valid,
  input logic [DATA_W-1:0] mem_rsp_data,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_hit,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !req_ready) |=> (rsp_valid && !rsp_hit)); // R3
  AST_FILL_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && !req_ready) |=> (rsp_data == $past(mem_rsp_data))); // R3
  AST_STALL_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !req_ready); // R8
  AST_NO_FETCH_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !mem_req_valid); // R8
  AST_HIT_NEEDS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> $past(req_valid && req_keep && !mem_req_valid)); // R7
  AST_HIT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (hit_count == $past(hit_count) + 1'b1)); // R9
  AST_BYPASS_NO_MISS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !req_keep) |=> $stable(miss_count)); // R7
endmodule

bind embed_cache embed_cache_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_keep(req_keep),
  .req_ready(req_ready), .mem_req_valid(mem_req_valid),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
  .hit_count(hit_count), .miss_count(miss_count));

// File: tb/tb_embed_cache.sv
module tb_embed_cache;
  localparam int ADDR_W = 16, DATA_W = 32, SETS = 4, WAYS = 4, CNT_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_keep = 1'b0, mem_rsp_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] mem_rsp_data = '0;
  logic req_ready, mem_req_valid, rsp_valid, rsp_hit;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] rsp_data;
  logic [CNT_W-1:0] hit_count, miss_count;

  always #10 clk = ~clk;

  embed_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_keep(req_keep), .req_ready(req_ready), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_hit(rsp_hit), .hit_count(hit_count), .miss_count(miss_count));

  int total = 0, bad = 0;
  int exp_hits = 0, exp_miss = 0;
  bit exp_busy = 0, running = 0, finished = 0;
  int lru [SETS][$];

  function automatic logic [DATA_W-1:0] memfn(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk)
    if (running) check(req_ready == !exp_busy, "R8", "req_ready", req_ready, !exp_busy);

  task automatic access(input logic [ADDR_W-1:0] a, input bit k, input string rq);
    int s, pos;
    logic [ADDR_W-1:0] t;
    bit h;
    s = int'(a[1:0]);
    t = a >> 2;
    h = 0; pos = 0;
    if (k) foreach (lru[s][i]) if (lru[s][i] == t) begin h = 1; pos = i; end
    @(negedge clk);
    req_valid = 1; req_addr = a; req_keep = k;
    #1;
    check(mem_req_valid == !h, rq, "mem_req_valid", mem_req_valid, !h);
    if (!h) check(mem_req_addr == a, "R3", "mem_req_addr", mem_req_addr, a);
    @(posedge clk);
    if (!h) exp_busy = 1;
    if (k && h) exp_hits++;
    if (k && !h) exp_miss++;
    @(negedge clk);
    if (!h) begin
      req_addr = a ^ 16'h0104;
      repeat (1 + int'(a % 3)) begin
        #1;
        check(!mem_req_valid, "R8", "stalled fetch", mem_req_valid, 0);
        @(negedge clk);
      end
      req_valid = 0;
      mem_rsp_valid = 1; mem_rsp_data = memfn(a);
      @(posedge clk);
      exp_busy = 0;
      @(negedge clk);
      mem_rsp_valid = 0;
    end else req_valid = 0;
    check(rsp_valid == 1, rq, "rsp_valid", rsp_valid, 1);
    check(rsp_hit == h, rq, "rsp_hit", rsp_hit, h);
    check(rsp_data == memfn(a), rq, "rsp_data", rsp_data, memfn(a));
    check(hit_count == CNT_W'(exp_hits), "R9", "hit_count", hit_count, exp_hits);
    check(miss_count == CNT_W'(exp_miss), "R9", "miss_count", miss_count, exp_miss);
    if (k) begin
      if (h) lru[s].delete(pos);
      else if (lru[s].size() == WAYS) void'(lru[s].pop_back());
      lru[s].push_front(t);
    end
    @(negedge clk);
    check(rsp_valid == 0, rq, "rsp pulse", rsp_valid, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    rst_n = 1;
    running = 1;
    check(rsp_valid == 0, "R1", "rsp_valid", rsp_valid, 0);
    check(req_ready == 1, "R1", "req_ready", req_ready, 1);
    check(hit_count == 0 && miss_count == 0, "R1", "counters", hit_count, 0);
    access(16'h0010, 1, "R1");
    access(16'h0010, 1, "R4");
    access(16'h0020, 1, "R5"); access(16'h0030, 1, "R5"); access(16'h0040, 1, "R5");
    access(16'h0010, 1, "R5"); access(16'h0020, 1, "R5");
    access(16'h0030, 1, "R5"); access(16'h0040, 1, "R5");
    access(16'h0010, 1, "R6");
    access(16'h0050, 1, "R6");
    access(16'h0020, 1, "R6");
    access(16'h0010, 1, "R6");
    access(16'h0011, 0, "R7");
    access(16'h0011, 1, "R7");
    access(16'h0010, 0, "R7");
    access(16'h0101, 1, "R7"); access(16'h0201, 1, "R7"); access(16'h0301, 1, "R7");
    access(16'h0501, 0, "R7");
    access(16'h0101, 0, "R7");
    access(16'h0401, 1, "R7");
    access(16'h0011, 1, "R7");
    access(16'h0201, 1, "R2");
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      access({9'd0, lf[6:4], 2'd0, lf[1:0]}, lf[11:9] != 3'd0, "R6");
    end
    running = 0;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule